// File: doc/BRIEF.md
# Sentence Capture Buffer

This block sits after a byte-oriented serial receiver and pulls one complete ASCII sentence out of a stream that may already be running when capture is requested. After a request it drops every incoming byte until a `$` (0x24) arrives. From there it stores bytes into a local buffer until the byte stored equals a programmable end character or the buffer is full. It then pulses a done strobe and reports how many bytes it kept.

The stored sentence is read back by index through a synchronous read port. If the receiver reports a framing error partway through a sentence, the partial sentence is abandoned and the block goes back to looking for `$`. Checksum and field decoding happen downstream.

Top module: `sentence_capture`

## Requirements
- R1: While hunting, every valid byte other than 0x24 is discarded. A valid, error-free 0x24 is stored at index 0 and starts the fill phase.
- R2: During fill, each valid, error-free byte is written at the next index (1, 2, ...). After done it reads back at that index.
- R3: When a stored byte equals end_char_i, capture ends with ovf_o=0 and len_o equal to the number of stored bytes, counting the 0x24 and the terminator. This also holds when the terminator is the 128th byte, and when end_char_i is 0x24 itself (len_o=1).
- R4: If the 128th stored byte is not the end character, capture ends with len_o=128 and ovf_o=1. Later bytes are not stored and produce no further done.
- R5: done_o is high for exactly one cycle, in the cycle after the ending byte is accepted. len_o and ovf_o take their new values at that same edge and hold until the next accepted request.
- R6: A valid byte flagged with rx_ferr_i during fill is not stored. It aborts the sentence with no done and restarts hunting from index 0. During hunting, a flagged byte is dropped even if it is 0x24.
- R7: req_i is accepted only when idle (after reset or after done). Acceptance clears len_o and ovf_o at the next edge and starts hunting. A request that arrives while hunting or filling has no effect.
- R8: Without an accepted request, incoming bytes are ignored and no done is produced.
- R9: After reset done_o=0, len_o=0 and ovf_o=0. rd_data_o shows the buffer byte at rd_addr_i one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Capture request pulse |
| rx_data_i | input | 8 | Received byte |
| rx_vld_i | input | 1 | rx_data_i valid strobe |
| rx_ferr_i | input | 1 | Framing error on the strobed byte |
| end_char_i | input | 8 | Sentence terminator |
| done_o | output | 1 | Capture complete pulse |
| len_o | output | 8 | Stored byte count (0..128) |
| ovf_o | output | 1 | Capture stopped at buffer limit |
| rd_addr_i | input | 7 | Buffer read index |
| rd_data_o | output | 8 | Buffer byte at rd_addr_i, one cycle latency |

## Verification
The assertions assume the following about the inputs:
- rx_vld_i is a strobe that qualifies rx_data_i and rx_ferr_i, and rx_ferr_i matters only while rx_vld_i is high.
- end_char_i does not change during a capture.
- req_i is a short pulse.

The stimulus keeps to these rules. It drives each byte for a single cycle followed by one idle cycle, changes the terminator only while the block is idle, and raises requests as one-cycle pulses. Sentence lengths are swept from 2 to 131 so that capture ends on both sides of the 128-byte limit. Every stored byte is read back and compared with the value the bench computed for it.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_FILL = 2'd2
  } sc_state_e;

  localparam logic [7:0] SC_START_BYTE = 8'h24;
endpackage

// File: rtl/sc_buf.sv
module sc_buf #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              vld_i,
  input  logic              ferr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] end_char_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic              done_o,
  output logic [CW-1:0]     len_o,
  output logic              ovf_o
);
  sc_state_e   state_q;
  logic [AW-1:0] idx_q;
  logic [CW-1:0] len_q;
  logic          ovf_q, done_q;

  logic clean, take, hit_end, at_last;

  always_comb begin
    clean   = vld_i && !ferr_i;
    take    = clean && ((state_q == ST_FILL) ||
              (state_q == ST_HUNT && data_i == DATA_W'(SC_START_BYTE)));
    waddr_o = (state_q == ST_HUNT) ? '0 : idx_q;
    we_o    = take;
    hit_end = (data_i == end_char_i);
    at_last = (waddr_o == AW'(DEPTH - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_HUNT;
          idx_q   <= '0;
          len_q   <= '0;
          ovf_q   <= 1'b0;
        end
        ST_HUNT: if (take) begin
          if (hit_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            len_q   <= CW'(1);
          end else begin
            state_q <= ST_FILL;
            idx_q   <= AW'(1);
          end
        end
        ST_FILL: begin
          if (vld_i && ferr_i) begin
            state_q <= ST_HUNT;   // abandon partial sentence
            idx_q   <= '0;
          end else if (take) begin
            if (hit_end) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              len_q   <= {1'b0, idx_q} + CW'(1);
            end else if (at_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              len_q   <= CW'(DEPTH);
              ovf_q   <= 1'b1;
            end else begin
              idx_q <= idx_q + AW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign len_o  = len_q;
  assign ovf_o  = ovf_q;

  p_hunt_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && vld_i && data_i != DATA_W'(SC_START_BYTE)) |=>
      (state_q == ST_HUNT && !done_q))
    else $error("hunt left on non-start byte");

  p_fill_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && take && !hit_end && !at_last) |=>
      (state_q == ST_FILL && idx_q == $past(idx_q) + AW'(1)))
    else $error("fill index did not advance");

  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && vld_i && ferr_i) |=>
      (state_q == ST_HUNT && idx_q == '0 && !done_q))
    else $error("framing error did not abort");

  p_req_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i) |=> (len_q == '0 && !ovf_q && state_q == ST_HUNT))
    else $error("request did not clear");

  p_req_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && req_i && !vld_i) |=> $stable(state_q))
    else $error("request disturbed capture");

  p_len_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_IDLE && req_i) |=> (done_q || $stable(len_q)))
    else $error("len changed without done");
endmodule

// File: rtl/sentence_capture.sv
module sentence_capture #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_vld_i,
  input  logic              rx_ferr_i,
  input  logic [DATA_W-1:0] end_char_i,
  output logic              done_o,
  output logic [CW-1:0]     len_o,
  output logic              ovf_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic          we;
  logic [AW-1:0] waddr;

  sc_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .vld_i      (rx_vld_i),
    .ferr_i     (rx_ferr_i),
    .data_i     (rx_data_i),
    .end_char_i (end_char_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .done_o     (done_o),
    .len_o      (len_o),
    .ovf_o      (ovf_o)
  );

  sc_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (we),
    .wr_addr_i (waddr),
    .wr_data_i (rx_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  p_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= CW'(DEPTH))
    else $error("len beyond depth");

  p_ovf_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> len_o == CW'(DEPTH))
    else $error("overflow without full count");

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_done_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_o != '0)
    else $error("done with empty count");
endmodule

// File: tb/sentence_capture_tb.sv
module sentence_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_vld = 1'b0;
  logic       rx_ferr = 1'b0;
  logic [7:0] end_char = 8'h0A;
  logic       done;
  logic [7:0] len;
  logic       ovf;
  logic [6:0] rd_addr = 7'd0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sentence_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rx_data_i(rx_data),
    .rx_vld_i(rx_vld), .rx_ferr_i(rx_ferr), .end_char_i(end_char),
    .done_o(done), .len_o(len), .ovf_o(ovf),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic e = 1'b0);
    @(negedge clk);
    rx_data = b; rx_vld = 1'b1; rx_ferr = e;
    @(negedge clk);
    rx_vld = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_addr = 7'(a);
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic [7:0] fill_byte(input int n, input int k);
    return 8'(8'h41 + ((n + k) % 26));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done after reset", int'(done), 0);
    check("R9 len after reset", int'(len), 0);
    check("R9 ovf after reset", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 bytes without a request
    send(8'h24); send(8'h41); send(8'h0A);
    @(negedge clk);
    check("R8 no done without request", done_cnt, 0);

    // R1/R2/R3 sweep over sentence lengths, R4 beyond the limit
    for (int n = 2; n <= 131; n++) begin
      base = done_cnt;
      pulse_req();
      check("R7 len cleared", int'(len), 0);
      check("R7 ovf cleared", int'(ovf), 0);
      send(8'h5A); send(8'h0A);   // dropped while hunting (R1)
      send(8'h24);
      for (int k = 1; k <= n - 2; k++) send(fill_byte(n, k));
      if (n <= 128) begin
        send(8'h0A);
        check("R5 done pulse at end", int'(done), 1);
        @(negedge clk);
        check("R5 done single cycle", int'(done), 0);
        check("R3 len", int'(len), n);
        check("R3 ovf clear", int'(ovf), 0);
      end else begin
        send(8'h0A);
        @(negedge clk);
        check("R4 len at limit", int'(len), 128);
        check("R4 ovf set", int'(ovf), 1);
      end
      check("R5 one done per sentence", done_cnt - base, 1);
      for (int k = 0; k < ((n > 128) ? 128 : n); k++) begin
        rd(k, d);
        if (k == 0)                check("R1 start byte stored", int'(d), 8'h24);
        else if (k == n - 1)       check("R3 terminator stored", int'(d), 8'h0A);
        else                       check("R2 fill byte", int'(d), int'(fill_byte(n, k)));
      end
    end

    // R4 no further done after overflow
    base = done_cnt;
    send(8'h24); send(8'h0A);
    @(negedge clk);
    check("R4 idle after overflow", done_cnt - base, 0);

    // R6 framing error aborts
    base = done_cnt;
    pulse_req();
    send(8'h24); send(8'h41); send(8'h42);
    send(8'h24, 1'b1);           // aborts fill
    send(8'h5A);
    send(8'h24, 1'b1);           // flagged start dropped while hunting
    send(8'h24); send(8'h51); send(8'h0A);
    @(negedge clk);
    check("R6 single done after abort", done_cnt - base, 1);
    check("R6 len after abort", int'(len), 3);
    rd(0, d); check("R6 byte0", int'(d), 8'h24);
    rd(1, d); check("R6 byte1", int'(d), 8'h51);
    rd(2, d); check("R6 byte2", int'(d), 8'h0A);

    // R7 request ignored during fill and during hunt
    base = done_cnt;
    pulse_req();
    send(8'h24); send(8'h42);
    pulse_req();
    send(8'h43); send(8'h0A);
    @(negedge clk);
    check("R7 req ignored in fill: done", done_cnt - base, 1);
    check("R7 req ignored in fill: len", int'(len), 4);
    rd(2, d); check("R7 byte2 kept", int'(d), 8'h43);
    base = done_cnt;
    pulse_req();
    pulse_req();
    send(8'h24); send(8'h0A);
    @(negedge clk);
    check("R7 req ignored in hunt: len", int'(len), 2);
    check("R7 req ignored in hunt: done", done_cnt - base, 1);

    // R3 other terminators, '$' in the body stored as data
    end_char = 8'h2A;
    pulse_req();
    send(8'h24); send(8'h24); send(8'h0A); send(8'h2A);
    @(negedge clk);
    check("R3 star terminator len", int'(len), 4);
    rd(1, d); check("R2 inner start byte stored", int'(d), 8'h24);
    end_char = 8'h24;
    pulse_req();
    send(8'h41); send(8'h24);
    @(negedge clk);
    check("R3 start equals terminator len", int'(len), 1);
    check("R3 start equals terminator ovf", int'(ovf), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule